// File: doc/BRIEF.md
# Chained Byte Cipher Buffer Engine

This engine runs a lightweight chained byte cipher over a 128-byte buffer that sits in an external dual-port RAM. After a start pulse, it reads each source byte in turn through the RAM's read port. Each byte is combined with a running key and goes through a nibble swap, and the result is written through the RAM's write port into the upper half of the memory, filling it from the top address downward. The mode input selects encryption or decryption. It is sampled on the cycle that start is accepted, together with the one-byte starting key.

After the first byte, the key depends on the mode. In encryption it is the ciphertext byte just produced. In decryption it is the ciphertext byte just consumed. Because of this, decrypting a buffer with the same starting key undoes an earlier encryption. The engine processes one byte per clock. It accounts for the RAM's one-cycle read latency. When the last result is written, it raises a single-cycle completion pulse.

Top module: `chain_cipher_engine`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, rd_en, wr_en and done are all 0.
- R2: With mode = 0 (encrypt), each output byte is the input byte XOR the current key, with its upper four bits and lower four bits then exchanged.
- R3: In encrypt mode, the key for byte i+1 is the output byte produced for byte i.
- R4: With mode = 1 (decrypt), each output byte is the input byte with its two nibbles exchanged, then XORed with the current key.
- R5: In decrypt mode, the key for byte i+1 is the input byte read for byte i.
- R6: Byte 0 uses key_in, and the whole run uses the mode. Both are sampled on the clock edge where start is accepted. Later changes to key_in or mode have no effect on that run.
- R7: If start is accepted at edge E0, rd_en is high for exactly the 128 cycles following edges E0..E127, with rd_addr = 0, 1, ..., 127 in that order. The RAM returns data one cycle after a read strobe.
- R8: The result for source address i is presented with wr_en high after edge E(i+2), at wr_addr = 255 - i. Writes therefore fall on consecutive cycles, going from 255 down to 128.
- R9: done is high for exactly one cycle, the cycle after the write to address 128 (after edge E130). The engine can accept a new start from the next edge onward.
- R10: A start that arrives from edge E0 up to and including edge E130 is ignored.
- R11: While idle, rd_en and wr_en stay low, and rd_addr and wr_addr hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when the engine is idle |
| mode | input | 1 | 0 = encrypt, 1 = decrypt; sampled at start |
| key_in | input | 8 | Starting key; sampled at start |
| rd_en | output | 1 | RAM read strobe |
| rd_addr | output | 8 | RAM read address (0..127) |
| rd_data | input | 8 | RAM read data, valid one cycle after rd_en |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | 8 | RAM write address (255..128) |
| wr_data | output | 8 | Result byte to be written |
| done | output | 1 | Single-cycle completion pulse |

## Verification
The assertions make three assumptions about the environment. Reset is held low from time zero. The RAM returns rd_data exactly one cycle after a read strobe. The source half of the buffer is not rewritten while a run is in progress. The bench meets these assumptions with a RAM model that registers read data on the strobe edge. It loads the buffer only between runs. All inputs are driven on the falling edge. Under these conditions, the address-step and done-pulse properties depend only on the engine's own sequencing, while stray start pulses and mid-run key or mode changes are still applied to test R6 and R10.

// File: rtl/cbc_eng_pkg.sv
package cbc_eng_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } eng_state_e;

    typedef enum logic {
        MODE_ENC = 1'b0,
        MODE_DEC = 1'b1
    } eng_mode_e;

endpackage

// File: rtl/cipher_byte_xform.sv
// Combinational byte stage: XOR with key plus half-width swap, ordered by mode.
module cipher_byte_xform
    import cbc_eng_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  eng_mode_e         mode,
    input  logic [DATA_W-1:0] in_byte,
    input  logic [DATA_W-1:0] key,
    output logic [DATA_W-1:0] out_byte,
    output logic [DATA_W-1:0] next_key
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] mixed;
    logic [DATA_W-1:0] mixed_sw;
    logic [DATA_W-1:0] in_sw;

    assign mixed = in_byte ^ key;

    for (genvar g = 0; g < HALF; g++) begin : g_swap
        assign mixed_sw[g]        = mixed[g + HALF];
        assign mixed_sw[g + HALF] = mixed[g];
        assign in_sw[g]           = in_byte[g + HALF];
        assign in_sw[g + HALF]    = in_byte[g];
    end

    always_comb begin
        if (mode == MODE_DEC) begin
            out_byte = in_sw ^ key;
            next_key = in_byte;
        end else begin
            out_byte = mixed_sw;
            next_key = mixed_sw;
        end
    end
endmodule

// File: rtl/cipher_addr_map.sv
// Maps a byte index to its source address and its mirrored destination address.
module cipher_addr_map #(
    parameter int DEPTH  = 128,
    parameter int IDX_W  = 7,
    parameter int ADDR_W = 8
) (
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  wr_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam int TOP_ADDR = 2 * DEPTH - 1;

    assign rd_addr = ADDR_W'(rd_idx);

    if ((1 << IDX_W) == DEPTH) begin : g_pow2
        assign wr_addr = {1'b1, ~wr_idx};
    end else begin : g_generic
        assign wr_addr = ADDR_W'(TOP_ADDR) - ADDR_W'(wr_idx);
    end
endmodule

// File: rtl/chain_cipher_engine.sv
module chain_cipher_engine
    import cbc_eng_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic [DATA_W-1:0] key_in,
    output logic              rd_en,
    output logic [$clog2(2*DEPTH)-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [$clog2(2*DEPTH)-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);
    localparam int ADDR_W = $clog2(2 * DEPTH);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] FINAL_WR = ADDR_W'(DEPTH);

    typedef struct packed {
        eng_state_e        state;
        eng_mode_e         mode;
        logic [DATA_W-1:0] key;
        logic              rd_en;
        logic [IDX_W-1:0]  rd_idx;
        logic              vld;
        logic [IDX_W-1:0]  vld_idx;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              done;
    } eng_reg_t;

    eng_reg_t q, d;

    logic [ADDR_W-1:0] map_rd_addr;
    logic [ADDR_W-1:0] map_wr_addr;
    logic [DATA_W-1:0] xf_out;
    logic [DATA_W-1:0] xf_key;

    cipher_addr_map #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W),
        .ADDR_W(ADDR_W)
    ) u_map (
        .rd_idx (q.rd_idx),
        .wr_idx (q.vld_idx),
        .rd_addr(map_rd_addr),
        .wr_addr(map_wr_addr)
    );

    cipher_byte_xform #(
        .DATA_W(DATA_W)
    ) u_xform (
        .mode    (q.mode),
        .in_byte (rd_data),
        .key     (q.key),
        .out_byte(xf_out),
        .next_key(xf_key)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.wr_en   = 1'b0;
        d.vld     = q.rd_en;
        d.vld_idx = q.rd_idx;
        unique case (q.state)
            ST_IDLE: begin
                d.rd_en = 1'b0;
                d.vld   = 1'b0;
                if (start) begin
                    d.state  = ST_RUN;
                    d.mode   = eng_mode_e'(mode);
                    d.key    = key_in;
                    d.rd_en  = 1'b1;
                    d.rd_idx = '0;
                end
            end
            ST_RUN: begin
                if (q.rd_en) begin
                    if (q.rd_idx == LAST_IDX) begin
                        d.rd_en = 1'b0;
                    end else begin
                        d.rd_idx = q.rd_idx + IDX_W'(1);
                    end
                end
                if (q.vld) begin
                    d.wr_en   = 1'b1;
                    d.wr_addr = map_wr_addr;
                    d.wr_data = xf_out;
                    d.key     = xf_key;
                end
                if (q.wr_en && (q.wr_addr == FINAL_WR)) begin
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_en   = q.rd_en;
    assign rd_addr = map_rd_addr;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign done    = q.done;
endmodule

// File: rtl/chain_cipher_engine_chk.sv
module chain_cipher_engine_chk #(
    parameter int DEPTH  = 128,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              done
);
    localparam logic [ADDR_W-1:0] HALF_ADDR = ADDR_W'(DEPTH);

    assert_rd_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr < HALF_ADDR));

    assert_rd_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> ((rd_addr - $past(rd_addr)) == ADDR_W'(1)));

    assert_wr_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr >= HALF_ADDR));

    assert_wr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (($past(wr_addr) - wr_addr) == ADDR_W'(1)));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == HALF_ADDR)) |=> done);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_en && !wr_en));
endmodule

bind chain_cipher_engine chain_cipher_engine_chk #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .done   (done)
);

// File: tb/chain_cipher_engine_tb.sv
`timescale 1ns/1ps
module chain_cipher_engine_tb;
    localparam int N = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode = 1'b0;
    logic [7:0] key_in = 8'h00;
    logic       rd_en, wr_en, done;
    logic [7:0] rd_addr, wr_addr, wr_data;
    logic [7:0] rd_data = 8'h00;

    logic [7:0] mem [256];
    logic [7:0] orig [N];
    logic [7:0] exp_out [N];

    int n_checks = 0;
    int n_errs = 0;
    int cyc = 200;
    bit m_busy = 1'b0;
    logic [7:0] prev_rd_addr = 8'h00;
    logic [7:0] prev_wr_addr = 8'h00;

    always #10 clk = ~clk;

    chain_cipher_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .key_in(key_in),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    // RAM model: read data registered on the strobe edge.
    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    function automatic logic [7:0] nsw(input logic [7:0] b);
        return {b[3:0], b[7:4]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: run timing and expected results.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0;
            cyc = 200;
        end else if (m_busy) begin
            cyc++;
            if (cyc == 130) m_busy = 1'b0;
        end else begin
            if (cyc == 130) cyc = 131;
            if (start) begin
                logic [7:0] k;
                k = key_in;
                for (int i = 0; i < N; i++) begin
                    if (!mode) begin
                        exp_out[i] = nsw(mem[i] ^ k);
                        k = exp_out[i];
                    end else begin
                        exp_out[i] = nsw(mem[i]) ^ k;
                        k = mem[i];
                    end
                end
                m_busy = 1'b1;
                cyc = 0;
            end
        end
    end

    // Per-clock comparison.
    always @(negedge clk) begin
        if (rst_n) begin
            logic e_rd, e_wr;
            e_rd = m_busy && (cyc <= 127);
            e_wr = m_busy && (cyc >= 2) && (cyc <= 129);
            chk("R7 rd_en", 32'(rd_en), 32'(e_rd));
            if (e_rd) chk("R7 rd_addr", 32'(rd_addr), 32'(cyc));
            chk("R8 wr_en", 32'(wr_en), 32'(e_wr));
            if (e_wr) begin
                chk("R8 wr_addr", 32'(wr_addr), 32'(255 - (cyc - 2)));
                chk("R2 or R4 wr_data", 32'(wr_data), 32'(exp_out[cyc - 2]));
            end
            chk("R9 done", 32'(done), 32'(cyc == 130));
            if (!m_busy && cyc != 0) begin
                chk("R11 rd_addr hold", 32'(rd_addr), 32'(prev_rd_addr));
                chk("R11 wr_addr hold", 32'(wr_addr), 32'(prev_wr_addr));
            end
            prev_rd_addr = rd_addr;
            prev_wr_addr = wr_addr;
        end
    end

    task automatic kick(input logic m, input logic [7:0] k);
        @(negedge clk);
        mode = m;
        key_in = k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int exp_cycles);
        int n = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R9 cycles to done", 32'(n), 32'(exp_cycles));
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_errs++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 rd_en in reset", 32'(rd_en), 0);
        chk("R1 wr_en in reset", 32'(wr_en), 0);
        chk("R1 done in reset", 32'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_en after reset", 32'(rd_en), 0);
        chk("R1 done after reset", 32'(done), 0);

        // Encrypt, key 0x5A
        for (int i = 0; i < N; i++) begin
            mem[i] = 8'(i * 7 + 3);
            orig[i] = mem[i];
        end
        kick(1'b0, 8'h5A);
        wait_done(130);
        chk("R2 first byte", 32'(mem[255]), 32'h95);
        chk("R3 chained second byte", 32'(mem[254]), 32'hF9);

        // Decrypt the ciphertext back, same key
        for (int i = 0; i < N; i++) mem[i] = mem[255 - i];
        kick(1'b1, 8'h5A);
        wait_done(130);
        chk("R4 first byte", 32'(mem[255]), 32'h03);
        for (int i = 0; i < N; i++) chk("R5 round trip", 32'(mem[255 - i]), 32'(orig[i]));

        // Mid-run input changes and stray starts
        for (int i = 0; i < N; i++) mem[i] = 8'(255 - 3 * i);
        kick(1'b0, 8'hC3);
        mode = 1'b1;
        key_in = 8'h11;
        repeat (40) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (87) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R6 sampled key and mode", 32'(mem[255]), 32'(nsw(8'hFF ^ 8'hC3)));
        chk("R10 no restart", 32'(rd_en), 0);

        // Idle period
        repeat (20) @(negedge clk);
        chk("R11 idle rd_en", 32'(rd_en), 0);
        chk("R11 idle wr_en", 32'(wr_en), 0);

        // Start held high: two back-to-back runs, zero key, all-ones data
        for (int i = 0; i < N; i++) mem[i] = 8'hFF;
        begin
            int dones = 0;
            @(negedge clk);
            mode = 1'b0;
            key_in = 8'h00;
            start = 1'b1;
            for (int n = 0; n < 400 && dones < 2; n++) begin
                @(negedge clk);
                if (done) dones++;
            end
            start = 1'b0;
            chk("R9 back-to-back done pulses", 32'(dones), 2);
        end
        repeat (3) @(negedge clk);
        chk("R2 zero-key first byte", 32'(mem[255]), 32'hFF);
        chk("R3 zero-key second byte", 32'(mem[254]), 32'h00);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end
endmodule